// File: doc/BRIEF.md
# Packed Widening Multiply-Accumulate Lane

This block is a packed SIMD datapath for a vector unit. One request carries a 64-bit word of first multiplicands, a second multiplicand source and a 128-bit accumulator word. Every element of the word is processed in parallel. Each element multiplies two narrow values, and the result has twice the element width. The element width is either 8 or 16 bits. For each element, the 2*SEW-bit product is added to the matching 2*SEW-bit accumulator element, and the 128-bit result is registered.

The second multiplicand comes from one of two places:
- a second 64-bit vector word, in the vector-vector form;
- a 32-bit scalar register value broadcast to every element, in the vector-scalar form.

In the scalar form only the low SEW bits of the scalar count. They are sign- or zero-extended to 2*SEW according to the signedness variant before the multiply. The upper scalar bits never reach the arithmetic.

A request is presented with a valid strobe. Its result appears one clock later, together with an output valid. There is no backpressure.

Top module: `widen_mac_lane`

## Requirements
- R1: With sewSel=0 there are eight elements: element i of vecA/vecB is bits [8i+7:8i] and of accIn/result is bits [16i+15:16i]. With sewSel=1 there are four elements: vecA/vecB bits [16i+15:16i] and accIn/result bits [32i+31:32i]. Each result element equals ext(vecA_i)*ext(second_i)+accIn_i.
- R2: variant=0 zero-extends both multiplicands; variant=1 sign-extends both.
- R3: variant=2 sign-extends the second multiplicand (the vecB element or the scalar) and zero-extends the vecA element.
- R4: variant=3 with scalarForm=1 zero-extends the scalar and sign-extends the vecA element.
- R5: With scalarForm=1, every element's second multiplicand is scalarIn[SEW-1:0], extended per variant. scalarIn bits above SEW and all of vecB have no effect on the result.
- R6: Each element sum wraps modulo 2^(2*SEW), with no saturation and no carry into the neighbouring element.
- R7: An accepted request (inValid=1) raises outValid for exactly the following cycle, and result carries that request's value in the same cycle.
- R8: In a cycle with no accepted request, result holds its previous value and outValid is 0 in the next cycle.
- R9: variant=3 with scalarForm=0 is not accepted: outValid stays 0 and result is unchanged.
- R10: While rstN is low, outValid is 0 and result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| sewSel | input | 1 | Element width: 0 = 8 bits, 1 = 16 bits |
| variant | input | 2 | Signedness: 0 uu, 1 ss, 2 signed second/unsigned vecA, 3 unsigned scalar/signed vecA |
| scalarForm | input | 1 | 1 = broadcast scalar as second multiplicand |
| vecA | input | 64 | First multiplicand word |
| vecB | input | 64 | Second multiplicand word (vector form) |
| scalarIn | input | 32 | Scalar register value (scalar form) |
| accIn | input | 128 | Accumulator word |
| outValid | output | 1 | Result valid |
| result | output | 128 | Registered accumulation result |

## Verification
A wrong extension of the scalar shows at the ports one cycle after the request, as upper element bits that follow the scalar's high bits and not the sign of its low SEW bits. The upper bits of 0x3784F1C6 are chosen to differ from the sign of the low byte, so the 0xFFC6 pattern makes this fault obvious in a single result. An element-boundary mistake shows as a carry or lane misplacement in the same result word, because accumulators are driven to the wrap point. A decode fault in the control shows as a missing or extra outValid, or as a result that changes during idle or rejected cycles, within one clock.

// File: rtl/widen_mac_pkg.sv
package widen_mac_pkg;

  typedef enum logic [1:0] {
    VAR_UU = 2'd0,
    VAR_SS = 2'd1,
    VAR_SU = 2'd2,
    VAR_US = 2'd3
  } mac_variant_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic wide;      // 16-bit elements
    logic signMul;   // second multiplicand (vecB or scalar) is signed
    logic signVec;   // vecA element is signed
    logic useScalar; // broadcast scalar as second multiplicand
  } mac_strobe_t;

endpackage

// File: rtl/widen_mac_ctrl.sv
module widen_mac_ctrl
  import widen_mac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         sewSel,
  input  logic [1:0]   variant,
  input  logic         scalarForm,
  output mac_strobe_t  strobe,
  output logic         outValid
);

  mac_variant_e varSel;
  logic         legal;

  assign varSel = mac_variant_e'(variant);
  // unsigned-scalar/signed-vector exists only in scalar form
  assign legal  = !(varSel == VAR_US && !scalarForm);

  always_comb begin
    strobe.load      = inValid && legal;
    strobe.wide      = sewSel;
    strobe.useScalar = scalarForm;
    strobe.signMul   = (varSel == VAR_SS) || (varSel == VAR_SU);
    strobe.signVec   = (varSel == VAR_SS) || (varSel == VAR_US);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.load;
  end

  // R7: a load strobe is only issued for a presented request
  p_load_needs_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> inValid);

  // R9: vector-form unsigned/signed request never produces a valid result
  p_us_vv_reject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && variant == 2'd3 && !scalarForm) |=> !outValid);

endmodule

// File: rtl/widen_mac_datapath.sv
module widen_mac_datapath
  import widen_mac_pkg::*;
#(
  parameter int VEC_W    = 64,
  parameter int NARROW   = 8,
  parameter int SCALAR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mac_strobe_t          strobe,
  input  logic [VEC_W-1:0]     vecA,
  input  logic [VEC_W-1:0]     vecB,
  input  logic [SCALAR_W-1:0]  scalarIn,
  input  logic [2*VEC_W-1:0]   accIn,
  output logic [2*VEC_W-1:0]   result
);

  localparam int ACC_W   = 2 * VEC_W;
  localparam int N_SIZES = 2;

  logic [ACC_W-1:0] resAt [N_SIZES];
  logic             unusedScalarHi;

  assign unusedScalarHi = ^scalarIn[SCALAR_W-1:2*NARROW];

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int W     = NARROW << s;
    localparam int W2    = 2 * W;
    localparam int LANES = VEC_W / W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [W-1:0]  aEl;
      logic [W-1:0]  bEl;
      logic [W2-1:0] extA;
      logic [W2-1:0] extB;
      logic [W2-1:0] prod;

      assign aEl  = vecA[g*W +: W];
      // scalar: only its low element-width bits are taken
      assign bEl  = strobe.useScalar ? scalarIn[W-1:0] : vecB[g*W +: W];
      assign extA = {{W{strobe.signVec & aEl[W-1]}}, aEl};
      assign extB = {{W{strobe.signMul & bEl[W-1]}}, bEl};
      assign prod = extA * extB;
      assign resAt[s][g*W2 +: W2] = prod + accIn[g*W2 +: W2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           result <= '0;
    else if (strobe.load) result <= strobe.wide ? resAt[1] : resAt[0];
  end

  // R8: without a load the result register holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result));

endmodule

// File: rtl/widen_mac_lane.sv
module widen_mac_lane
  import widen_mac_pkg::*;
#(
  parameter int VEC_W    = 64,
  parameter int NARROW   = 8,
  parameter int SCALAR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                sewSel,
  input  logic [1:0]          variant,
  input  logic                scalarForm,
  input  logic [VEC_W-1:0]    vecA,
  input  logic [VEC_W-1:0]    vecB,
  input  logic [SCALAR_W-1:0] scalarIn,
  input  logic [2*VEC_W-1:0]  accIn,
  output logic                outValid,
  output logic [2*VEC_W-1:0]  result
);

  mac_strobe_t strobe;

  widen_mac_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .sewSel     (sewSel),
    .variant    (variant),
    .scalarForm (scalarForm),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  widen_mac_datapath #(
    .VEC_W    (VEC_W),
    .NARROW   (NARROW),
    .SCALAR_W (SCALAR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .vecA     (vecA),
    .vecB     (vecB),
    .scalarIn (scalarIn),
    .accIn    (accIn),
    .result   (result)
  );

  // R7: a valid result only follows a presented request
  p_valid_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

endmodule

// File: tb/widen_mac_lane_tb.sv
`timescale 1ns/1ps
module widen_mac_lane_tb;

  typedef struct packed {
    logic         wide;
    logic [1:0]   vsel;
    logic         sc;
    logic [63:0]  a;
    logic [63:0]  b;
    logic [31:0]  s;
    logic [127:0] acc;
  } stim_t;

  localparam int NROWS = 13;
  localparam stim_t TABLE [NROWS] = '{
    '{1'b0, 2'd0, 1'b0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 32'h0, 128'h0},
    '{1'b0, 2'd1, 1'b0, 64'h80FF7F0102FE8001, 64'h80FF7F01FF02017F, 32'h0, 128'h0123456789ABCDEF_FEDCBA9876543210},
    '{1'b0, 2'd2, 1'b0, 64'hFF80017F55AA00C3, 64'h80FF7FFF0101AA3C, 32'h0, 128'h1111_2222_3333_4444_5555_6666_7777_8888},
    '{1'b0, 2'd0, 1'b1, 64'h0102030405FF80C0, 64'hDEADBEEFDEADBEEF, 32'h3784F1C6, 128'h0},
    '{1'b0, 2'd1, 1'b1, 64'h0102030405FF80C0, 64'h0, 32'h3784F1C6, 128'hFFFF_0000_8000_7FFF_0001_1234_ABCD_0F0F},
    '{1'b0, 2'd2, 1'b1, 64'h7F80FF0001020304, 64'h0, 32'h000000FF, 128'h0},
    '{1'b0, 2'd3, 1'b1, 64'h7F80FF00010280FE, 64'h0, 32'hFFFFFF80, 128'h0},
    '{1'b1, 2'd0, 1'b0, 64'hFFFF8000_12347FFF, 64'hFFFF0002_ABCD8001, 32'h0, 128'h0},
    '{1'b1, 2'd1, 1'b1, 64'h8000FFFF00017FFF, 64'h0, 32'h00018000, 128'h0},
    '{1'b1, 2'd2, 1'b1, 64'h8000FFFF00017FFF, 64'h0, 32'hFFFF7FFF, 128'hFFFFFFFF_00000001_80000000_7FFFFFFF},
    '{1'b1, 2'd3, 1'b1, 64'h8000FFFF00017FFF, 64'h0, 32'h12348001, 128'h0},
    '{1'b1, 2'd2, 1'b0, 64'hFFFF8000_12347FFF, 64'hFFFF0002_ABCD8001, 32'h0, 128'h0},
    '{1'b0, 2'd1, 1'b0, 64'h7F7F7F7F7F7F7F7F, 64'h7F7F7F7F7F7F7F7F, 32'h0, {8{16'h7FFF}}}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         sewSel = 1'b0;
  logic [1:0]   variant = 2'd0;
  logic         scalarForm = 1'b0;
  logic [63:0]  vecA = '0;
  logic [63:0]  vecB = '0;
  logic [31:0]  scalarIn = '0;
  logic [127:0] accIn = '0;
  logic         outValid;
  logic [127:0] result;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  widen_mac_lane u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sewSel(sewSel),
    .variant(variant), .scalarForm(scalarForm), .vecA(vecA), .vecB(vecB),
    .scalarIn(scalarIn), .accIn(accIn), .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] refMac(stim_t t);
    int          w = t.wide ? 16 : 8;
    int          n = 64 / w;
    longint      mask = (longint'(1) << w) - 1;
    longint      amask = (longint'(1) << (2 * w)) - 1;
    bit          sVec = (t.vsel == 2'd1) || (t.vsel == 2'd3);
    bit          sMul = (t.vsel == 2'd1) || (t.vsel == 2'd2);
    logic [127:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0]  sa = t.a >> (i * w);
      logic [63:0]  sb = t.b >> (i * w);
      logic [127:0] sacc = t.acc >> (i * 2 * w);
      longint av = longint'(sa) & mask;
      longint bv = t.sc ? (longint'({32'b0, t.s}) & mask) : (longint'(sb) & mask);
      longint cv = longint'({32'b0, sacc[31:0]}) & amask;
      longint sum;
      logic [127:0] piece;
      if (sVec && av[w-1]) av = av - (longint'(1) << w);
      if (sMul && bv[w-1]) bv = bv - (longint'(1) << w);
      sum = (av * bv + cv) & amask;
      piece = {64'b0, 64'(sum)};
      r = r | (piece << (i * 2 * w));
    end
    return r;
  endfunction

  function automatic string tagOf(stim_t t);
    if (t.sc && t.vsel == 2'd3) return "R4";
    if (t.vsel == 2'd2)         return "R3";
    if (t.sc)                   return "R5";
    return "R2";
  endfunction

  task automatic check1(string req, logic [127:0] got, logic [127:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apply(stim_t t, logic v);
    @(negedge clk);
    sewSel = t.wide; variant = t.vsel; scalarForm = t.sc;
    vecA = t.a; vecB = t.b; scalarIn = t.s; accIn = t.acc; inValid = v;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    stim_t t;
    logic [127:0] held;
    // R10 reset state
    repeat (3) @(negedge clk);
    check1("R10 outValid", {127'b0, outValid}, 128'd0);
    check1("R10 result", result, 128'd0);
    rstN = 1'b1;

    // table walk: R1 element layout plus variant/form coverage
    for (int k = 0; k < NROWS; k++) begin
      apply(TABLE[k], 1'b1);
      check1({tagOf(TABLE[k]), " R1 row result"}, result, refMac(TABLE[k]));
      check1("R7 outValid after request", {127'b0, outValid}, 128'd1);
    end

    // R5 known pattern: signed low byte of 0x3784F1C6 broadcast as 0xFFC6
    t = '{1'b0, 2'd1, 1'b1, {8{8'h01}}, 64'h0, 32'h3784F1C6, 128'h0};
    apply(t, 1'b1);
    check1("R5 scalar extension 0xFFC6", result, {8{16'hFFC6}});

    // R5 vecB and upper scalar bits ignored in scalar form
    t = '{1'b0, 2'd1, 1'b1, {8{8'h01}}, 64'hA5A5_5A5A_FFFF_0000, 32'h0000_00C6, 128'h0};
    apply(t, 1'b1);
    check1("R5 vecB/upper scalar ignored", result, {8{16'hFFC6}});

    // R6 wrap at 32-bit element: FFFF*FFFF + FFFFFFFF -> FFFE0000
    t = '{1'b1, 2'd0, 1'b0, {4{16'hFFFF}}, {4{16'hFFFF}}, 32'h0, {4{32'hFFFFFFFF}}};
    apply(t, 1'b1);
    check1("R6 wrap no carry", result, {4{32'hFFFE0000}});

    // R8 idle cycle: hold, outValid low
    held = result;
    @(negedge clk);
    check1("R8 hold result", result, held);
    check1("R8 outValid low", {127'b0, outValid}, 128'd0);

    // R8 inputs change but inValid low
    t = '{1'b0, 2'd0, 1'b0, 64'h1111, 64'h2222, 32'h0, 128'h5};
    apply(t, 1'b0);
    check1("R8 no request keeps result", result, held);
    check1("R8 no request outValid", {127'b0, outValid}, 128'd0);

    // R9 unsigned/signed in vector form rejected
    t = '{1'b0, 2'd3, 1'b0, 64'h0102, 64'h0304, 32'h0, 128'h0};
    apply(t, 1'b1);
    check1("R9 rejected outValid", {127'b0, outValid}, 128'd0);
    check1("R9 rejected result", result, held);

    // R7 valid lasts exactly one cycle
    t = TABLE[0];
    apply(t, 1'b1);
    @(negedge clk);
    check1("R7 outValid single cycle", {127'b0, outValid}, 128'd0);

    // R10 reset mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    check1("R10 result cleared", result, 128'd0);
    check1("R10 outValid cleared", {127'b0, outValid}, 128'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule